// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits between two independent access ports and a shared memory array. Each port presents a chip enable, an address and a write request. The block registers these signals. When both ports select the same location in the same registered cycle, it lets one port proceed and raises a busy flag toward the other. It also gates the per-port write enables that go to the array, so that the port flagged busy cannot modify the location.

A mode input picks one of two roles. In master mode the block makes the arbitration decision itself, from the chip enables and addresses only, and drives the busy outputs. In slave mode it makes no decision. The busy inputs, which normally come from a master device covering the same address range, then act only as per-port write inhibits. Because of this, several devices placed side by side to widen the data word all block the same port's write.

Priority goes to the port that was already on the location in the previous cycle. If both ports arrive at the same time, the left port wins. Busy is resolved combinationally from the registered inputs, in the same cycle as the write gate that it controls.

Top module: `dp_collide_arb`

## Requirements
- R1: After reset, both busy outputs and both gated write enables are 0.
- R2: The chip enable, address and write request of each port are registered. Every output in a cycle reflects the inputs captured at the preceding rising clock edge. The slave busy inputs and the mode input act combinationally.
- R3: A collision exists only when both registered chip enables are 1 and the two registered addresses are equal. Without a collision, both busy outputs are 0.
- R4: At most one busy output is 1 in any cycle. When a collision starts with neither port holding the location from the previous cycle, or with both ports arriving in the same cycle, the left port wins, so busy_r_out is 1.
- R5: A port holds a location when it had the same chip-enabled address in the previous registered cycle. If only one colliding port holds the location, that port wins and the other port gets busy.
- R6: While both ports stay on the same collided address, the winner from the previous cycle keeps priority.
- R7: The read/write direction plays no part in the busy decision. Two colliding reads raise busy exactly as two writes do.
- R8: A gated write enable is 1 only when its port's registered chip enable and write request are both 1 and that port is not inhibited. In master mode a port is inhibited by its own busy output in the same cycle, so the losing port's write is never passed while the winner's write is.
- R9: With slave_mode at 1, both busy outputs are 0. busy_l_in inhibits l_we and busy_r_in inhibits r_we. An address collision on its own inhibits nothing.
- R10: Busy falls in the first registered cycle in which either port has dropped its chip enable or moved to a different address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1: slave role (busy inputs inhibit writes); 0: master role |
| l_ce | input | 1 | Left port chip enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| r_ce | input | 1 | Right port chip enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| busy_l_in | input | 1 | Left write inhibit, used in slave mode |
| busy_r_in | input | 1 | Right write inhibit, used in slave mode |
| busy_l_out | output | 1 | Left port busy (master mode) |
| busy_r_out | output | 1 | Right port busy (master mode) |
| l_we | output | 1 | Gated left write enable to the array |
| r_we | output | 1 | Gated right write enable to the array |

## Verification
The bench builds the block with the default ADDR_W of 11. This makes the top address 0x7FF and address 0 reachable as collision points, and the bench uses both. The 11-bit width also lets nearby distinct addresses, such as 0x7FE against 0x7FF, be driven to show that a near miss is not a collision. Scripted sequences cover both roles. They drive simultaneous arrivals, one port joining another that already holds the location, long collisions that keep the same winner, read-only collisions, and releases by chip enable or by address change.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;

  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } win_e;

  // Winner selection: a continuing collision keeps its previous winner,
  // a sole holder keeps the location, otherwise left is preferred.
  function automatic win_e pick_winner(input logic l_held, input logic r_held,
                                       input win_e prev_win);
    win_e w;
    if (l_held && r_held)      w = prev_win;
    else if (r_held)           w = WIN_RIGHT;
    else                       w = WIN_LEFT;
    return w;
  endfunction

  // Write gate: pass only an enabled, requested, uninhibited write.
  function automatic logic gate_write(input logic ce, input logic wr,
                                      input logic inhibit);
    return ce & wr & ~inhibit;
  endfunction

endpackage

// File: rtl/dp_port_stage.sv
module dp_port_stage #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic              ce_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_q,
  output logic              held_o
);

  logic              ce_p;
  logic [ADDR_W-1:0] addr_p;

  function automatic logic same_loc(input logic ca, input logic cb,
                                    input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] b);
    return ca & cb & (a == b);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      ce_p   <= 1'b0;
      addr_p <= '0;
    end else begin
      ce_q   <= ce_i;
      addr_q <= addr_i;
      wr_q   <= wr_i;
      ce_p   <= ce_q;
      addr_p <= addr_q;
    end
  end

  assign held_o = same_loc(ce_q, ce_p, addr_q, addr_p);

endmodule

// File: rtl/dp_busy_arb.sv
module dp_busy_arb
  import dp_arb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce_q,
  input  logic              r_ce_q,
  input  logic [ADDR_W-1:0] l_addr_q,
  input  logic [ADDR_W-1:0] r_addr_q,
  input  logic              l_held,
  input  logic              r_held,
  output logic              collide,
  output logic              busy_l,
  output logic              busy_r
);

  win_e win_q;
  win_e win_now;

  assign collide = l_ce_q & r_ce_q & (l_addr_q == r_addr_q);
  assign win_now = pick_winner(l_held, r_held, win_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= WIN_LEFT;
    else        win_q <= win_now;
  end

  assign busy_l = collide & (win_now == WIN_RIGHT);
  assign busy_r = collide & (win_now == WIN_LEFT);

endmodule

// File: rtl/dp_wr_gate.sv
module dp_wr_gate
  import dp_arb_pkg::*;
(
  input  logic slave_mode,
  input  logic ce_q,
  input  logic wr_q,
  input  logic busy_master,
  input  logic busy_ext,
  output logic inhibit,
  output logic we
);

  assign inhibit = slave_mode ? busy_ext : busy_master;
  assign we      = gate_write(ce_q, wr_q, inhibit);

endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              busy_l_in,
  input  logic              busy_r_in,
  output logic              busy_l_out,
  output logic              busy_r_out,
  output logic              l_we,
  output logic              r_we
);

  localparam int NPORT = 2;
  localparam int LEFT  = 0;
  localparam int RIGHT = 1;

  logic [NPORT-1:0]             ce_in, wr_in, ce_q, wr_q, held;
  logic [NPORT-1:0][ADDR_W-1:0] addr_in, addr_q;
  logic [NPORT-1:0]             busy_m, busy_x, inhibit, we;
  logic                         collide;
  logic                         arb_busy_l, arb_busy_r;

  assign ce_in   = {r_ce, l_ce};
  assign wr_in   = {r_wr, l_wr};
  assign addr_in = {r_addr, l_addr};
  assign busy_x  = {busy_r_in, busy_l_in};

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_port
      dp_port_stage #(.ADDR_W(ADDR_W)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_i   (ce_in[g]),
        .addr_i (addr_in[g]),
        .wr_i   (wr_in[g]),
        .ce_q   (ce_q[g]),
        .addr_q (addr_q[g]),
        .wr_q   (wr_q[g]),
        .held_o (held[g])
      );

      dp_wr_gate u_gate (
        .slave_mode  (slave_mode),
        .ce_q        (ce_q[g]),
        .wr_q        (wr_q[g]),
        .busy_master (busy_m[g]),
        .busy_ext    (busy_x[g]),
        .inhibit     (inhibit[g]),
        .we          (we[g])
      );
    end
  endgenerate

  dp_busy_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_ce_q   (ce_q[LEFT]),
    .r_ce_q   (ce_q[RIGHT]),
    .l_addr_q (addr_q[LEFT]),
    .r_addr_q (addr_q[RIGHT]),
    .l_held   (held[LEFT]),
    .r_held   (held[RIGHT]),
    .collide  (collide),
    .busy_l   (arb_busy_l),
    .busy_r   (arb_busy_r)
  );

  assign busy_m     = {arb_busy_r, arb_busy_l};
  assign busy_l_out = ~slave_mode & arb_busy_l;
  assign busy_r_out = ~slave_mode & arb_busy_r;
  assign l_we       = we[LEFT];
  assign r_we       = we[RIGHT];

endmodule

// File: rtl/dp_collide_chk.sv
module dp_collide_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_mode,
  input logic              l_ce_q,
  input logic              r_ce_q,
  input logic [ADDR_W-1:0] l_addr_q,
  input logic [ADDR_W-1:0] r_addr_q,
  input logic              l_held,
  input logic              r_held,
  input logic              busy_l_out,
  input logic              busy_r_out,
  input logic              l_we,
  input logic              r_we
);

  p_one_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_l_out && busy_r_out));

  p_busy_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l_out || busy_r_out) |-> (l_ce_q && r_ce_q && l_addr_q == r_addr_q));

  p_loser_blocked_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_l_out |-> !l_we);

  p_loser_blocked_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r_out |-> !r_we);

  p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (!busy_l_out && !busy_r_out));

  p_holder_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && r_held && !l_held && l_ce_q && l_addr_q == r_addr_q) |-> busy_l_out);

  p_winner_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && l_held && r_held && !$stable(slave_mode) == 1'b0 && $past(busy_r_out))
      |-> busy_r_out);

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(l_ce_q) || $fell(r_ce_q)) |-> (!busy_l_out && !busy_r_out));

endmodule

bind dp_collide_arb dp_collide_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slave_mode (slave_mode),
  .l_ce_q     (ce_q[0]),
  .r_ce_q     (ce_q[1]),
  .l_addr_q   (addr_q[0]),
  .r_addr_q   (addr_q[1]),
  .l_held     (held[0]),
  .r_held     (held[1]),
  .busy_l_out (busy_l_out),
  .busy_r_out (busy_r_out),
  .l_we       (l_we),
  .r_we       (r_we)
);

// File: tb/tb_dp_collide_arb.sv
module tb_dp_collide_arb;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slave_mode = 1'b0;
  logic          l_ce = 1'b0, l_wr = 1'b0, r_ce = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          busy_l_in = 1'b0, busy_r_in = 1'b0;
  logic          busy_l_out, busy_r_out, l_we, r_we;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference history
  bit          m_pl_ce = 0, m_pr_ce = 0, m_pwin = 0;
  int unsigned m_pl_a = 0, m_pr_a = 0;

  always #10 clk = ~clk;

  dp_collide_arb #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_ce(l_ce), .l_addr(l_addr), .l_wr(l_wr),
    .r_ce(r_ce), .r_addr(r_addr), .r_wr(r_wr),
    .busy_l_in(busy_l_in), .busy_r_in(busy_r_in),
    .busy_l_out(busy_l_out), .busy_r_out(busy_r_out),
    .l_we(l_we), .r_we(r_we)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Apply one registered access pair; busy inputs act in the following cycle.
  task automatic step(input string tag, input bit sm,
                      input bit lc, input int unsigned la, input bit lw,
                      input bit rc, input int unsigned ra, input bit rw,
                      input bit bli, input bit bri);
    bit lh, rh, col, win, e_bl, e_br, inh_l, inh_r;
    @(negedge clk);
    slave_mode = sm;
    l_ce = lc; l_addr = AW'(la); l_wr = lw;
    r_ce = rc; r_addr = AW'(ra); r_wr = rw;
    @(posedge clk);
    #1;
    busy_l_in = bli; busy_r_in = bri;
    #1;
    lh  = lc && m_pl_ce && (la == m_pl_a);
    rh  = rc && m_pr_ce && (ra == m_pr_a);
    col = lc && rc && (la == ra);
    if (lh && rh) win = m_pwin;
    else          win = rh;
    e_bl  = !sm && col && win;
    e_br  = !sm && col && !win;
    inh_l = sm ? bli : e_bl;
    inh_r = sm ? bri : e_br;
    check(tag, "busy_l_out", busy_l_out, e_bl);
    check(tag, "busy_r_out", busy_r_out, e_br);
    check(tag, "l_we", l_we, lc && lw && !inh_l);
    check(tag, "r_we", r_we, rc && rw && !inh_r);
    m_pl_ce = lc; m_pl_a = la; m_pr_ce = rc; m_pr_a = ra; m_pwin = win;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", "busy_l_out", busy_l_out, 1'b0);
    check("R1", "busy_r_out", busy_r_out, 1'b0);
    check("R1", "l_we", l_we, 1'b0);
    check("R1", "r_we", r_we, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R2/R3: distinct addresses, both write through
    step("R2", 0, 1, 12'h010, 1, 1, 12'h011, 1, 0, 0);
    step("R3", 0, 1, 12'h7FE, 1, 1, 12'h7FF, 1, 0, 0);
    // R3: same address, one side disabled
    step("R3", 0, 1, 12'h020, 1, 0, 12'h020, 1, 0, 0);
    step("R3", 0, 0, 12'h000, 0, 0, 12'h000, 0, 0, 0);
    // R4/R8: simultaneous arrival, left wins
    step("R4", 0, 1, 12'h7FF, 1, 1, 12'h7FF, 1, 0, 0);
    // R6: continuing collision keeps left
    step("R6", 0, 1, 12'h7FF, 1, 1, 12'h7FF, 1, 0, 0);
    step("R6", 0, 1, 12'h7FF, 0, 1, 12'h7FF, 1, 0, 0);
    // R10: right moves away
    step("R10", 0, 1, 12'h7FF, 1, 1, 12'h100, 1, 0, 0);
    // R5: right holds 0x100, left joins
    step("R5", 0, 1, 12'h200, 1, 1, 12'h100, 1, 0, 0);
    step("R5", 0, 1, 12'h100, 1, 1, 12'h100, 1, 0, 0);
    step("R6", 0, 1, 12'h100, 1, 1, 12'h100, 1, 0, 0);
    // R10: right drops chip enable
    step("R10", 0, 1, 12'h100, 1, 0, 12'h100, 1, 0, 0);
    // R5: left holds, right joins -> right busy
    step("R5", 0, 1, 12'h100, 1, 1, 12'h100, 1, 0, 0);
    // R7: reads only collide too
    step("R7", 0, 0, 12'h000, 0, 0, 12'h000, 0, 0, 0);
    step("R7", 0, 1, 12'h000, 0, 1, 12'h000, 0, 0, 0);
    step("R7", 0, 1, 12'h000, 1, 1, 12'h000, 0, 0, 0);
    // R10: left drops
    step("R10", 0, 0, 12'h000, 0, 1, 12'h000, 1, 0, 0);
    // R9: slave mode
    step("R9", 1, 1, 12'h055, 1, 1, 12'h055, 1, 0, 0);
    step("R9", 1, 1, 12'h055, 1, 1, 12'h055, 1, 1, 0);
    step("R9", 1, 1, 12'h055, 1, 1, 12'h066, 1, 0, 1);
    step("R9", 1, 1, 12'h055, 1, 1, 12'h066, 1, 1, 1);
    // R8: master ignores busy inputs
    step("R8", 0, 1, 12'h300, 1, 1, 12'h301, 1, 1, 1);
    step("R8", 0, 1, 12'h300, 1, 1, 12'h300, 1, 1, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule